// File: doc/BRIEF.md
# Synchronous Transfer Strobe Timing Generator

This block produces the outbound timing of a synchronous parallel-bus burst. It drives a strobe line and a one-cycle data-load enable that tells the data path when to put the next word on the bus. It also raises a one-cycle completion flag. Every interval is measured in input clocks. The base unit is a programmable divisor, and a divisor of zero is treated as one.

Two transfer modes exist. In single-edge mode each word is marked by one rising strobe edge, and the strobe pulses high for one unit. In double-edge mode the strobe level changes once per word. Words at even positions (the first, the third, and so on) are carried on the rising edge, and words at odd positions on the falling edge. Four extension bits each add exactly one clock, either to the setup before a kind of edge or to the hold after it. These bits stretch only the send timing. The mode, the divisor, the extension bits and the word count are captured when a burst starts and are held for the whole burst.

Top module: `stx_strobe_gen`

## Requirements
- R1: While `rst` is high, `strobe_o`, `load_o` and `done_o` are all 0, and `start_i` has no effect.
- R2: Let U = max(`div_i`,1). In single-edge mode (`dt_mode_i`=0), `load_o` is high in the first cycle after the clock edge that samples `start_i`. `strobe_o` rises 2U+`ext_i[0]` cycles after each load pulse and stays high for U cycles. The next load pulse follows the strobe rise by 2U+`ext_i[2]` cycles, so each word takes 4U+`ext_i[0]`+`ext_i[2]` cycles.
- R3: In double-edge mode (`dt_mode_i`=1), `strobe_o` changes level exactly once per word. At an even word position it rises U+`ext_i[0]` cycles after the load pulse, and the next load follows the rise by U+`ext_i[2]` cycles. At an odd word position it falls U+`ext_i[1]` cycles after the load pulse, and the next load follows the fall by U+`ext_i[3]` cycles.
- R4: In single-edge mode, `ext_i[1]` and `ext_i[3]` have no effect on any output.
- R5: A `div_i` value of 0 produces the same timing as a value of 1.
- R6: After the hold interval of the last word, `done_o` is high for exactly one cycle. In that cycle, and until the next load pulse, `strobe_o` is 0, even when a double-edge burst of odd length has left it high.
- R7: `div_i`, `dt_mode_i`, `ext_i` and `words_i` are sampled only at an accepted start. Changes to them, and further `start_i` pulses while a burst runs, do not alter the burst.
- R8: A start with `words_i`=0 gives `done_o` in the first cycle after the sampling edge, with no load pulse and no strobe activity.
- R9: `strobe_o` never changes level in a cycle where `load_o` is high. New data is driven only after the previous hold interval has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | DIV_W | Divisor giving the base unit in clocks (0 acts as 1) |
| dt_mode_i | input | 1 | 1 selects double-edge mode, 0 selects single-edge mode |
| ext_i | input | 4 | [0] rising-edge setup, [1] falling-edge setup, [2] rising-edge hold, [3] falling-edge hold; each adds one clock |
| start_i | input | 1 | Request to begin a burst; accepted only when idle |
| words_i | input | CNT_W | Number of words in the burst |
| strobe_o | output | 1 | Outbound transfer strobe |
| load_o | output | 1 | One-cycle pulse: drive the next data word |
| done_o | output | 1 | One-cycle pulse when the burst is complete |

## Verification
The bench targets four kinds of error. The first is an extension bit routed to the wrong edge or phase, which would shift a strobe edge or a load pulse by one cycle. The second is a falling-edge bit that leaks into single-edge mode and lengthens words that should not change. The third is a divisor of zero that is not clamped, which would collapse or wrap the phase timers. The fourth is configuration that is not latched, which would let a mid-burst change or a second start alter the timing. Odd-length double-edge bursts check that the strobe is parked low at completion. Zero-length bursts check that no load pulse leaks out.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HOLD  = 2'd2
    } stx_phase_e;

    // Burst configuration captured at start
    typedef struct packed {
        logic dt;      // double-edge mode
        logic ho_fall; // extra hold after falling (double-edge only) edge
        logic ho_rise; // extra hold after rising edge
        logic su_fall; // extra setup before falling edge
        logic su_rise; // extra setup before rising edge
    } stx_cfg_t;

    // Length of a setup or hold phase in clocks
    function automatic int unsigned phase_len(input int unsigned unit,
                                              input logic dt,
                                              input logic ext);
        int unsigned base;
        base = dt ? unit : 2 * unit;
        return base + (ext ? 1 : 0);
    endfunction

endpackage

// File: rtl/stx_cfg_capture.sv
module stx_cfg_capture
    import stx_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [DIV_W-1:0] div_i,
    input  logic             dt_i,
    input  logic [3:0]       ext_i,
    output logic [DIV_W-1:0] unit_o,
    output stx_cfg_t         cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_o <= DIV_W'(1);
            cfg_o  <= '0;
        end else if (capture) begin
            unit_o <= (div_i == '0) ? DIV_W'(1) : div_i;
            cfg_o  <= '{dt: dt_i, ho_fall: ext_i[3], ho_rise: ext_i[2],
                        su_fall: ext_i[1], su_rise: ext_i[0]};
        end
    end

endmodule

// File: rtl/stx_phase_timer.sv
module stx_phase_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [TW-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_o <= '0;
        end else begin
            count_o <= count_o + TW'(1);
        end
    end

endmodule

// File: rtl/stx_word_counter.sv
module stx_word_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] words_i,
    input  logic          dec,
    output logic          last_o
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= words_i;
        end else if (dec && remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign last_o = (remain == CW'(1));

endmodule

// File: rtl/stx_strobe_gen.sv
module stx_strobe_gen
    import stx_pkg::*;
#(
    parameter int DIV_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             dt_mode_i,
    input  logic [3:0]       ext_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] words_i,
    output logic             strobe_o,
    output logic             load_o,
    output logic             done_o
);

    localparam int TW = DIV_W + 2;

    stx_phase_e       phase;
    stx_cfg_t         cfg;
    logic [DIV_W-1:0] unit;
    logic [TW-1:0]    tcount;
    logic [TW-1:0]    setup_len;
    logic [TW-1:0]    hold_len;
    logic             odd_word;
    logic             last_word;
    logic             accept;
    logic             setup_end;
    logic             hold_end;
    logic             timer_clear;
    logic             use_fall;

    assign accept      = (phase == PH_IDLE) && start_i;
    assign use_fall    = cfg.dt && odd_word;
    assign setup_end   = (phase == PH_SETUP) && (tcount == setup_len - TW'(1));
    assign hold_end    = (phase == PH_HOLD) && (tcount == hold_len - TW'(1));
    assign timer_clear = (phase == PH_IDLE) || setup_end || hold_end;

    always_comb begin
        setup_len = TW'(phase_len(int'(unit), cfg.dt,
                                  use_fall ? cfg.su_fall : cfg.su_rise));
        hold_len  = TW'(phase_len(int'(unit), cfg.dt,
                                  use_fall ? cfg.ho_fall : cfg.ho_rise));
    end

    stx_cfg_capture #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .div_i   (div_i),
        .dt_i    (dt_mode_i),
        .ext_i   (ext_i),
        .unit_o  (unit),
        .cfg_o   (cfg)
    );

    stx_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .count_o (tcount)
    );

    stx_word_counter #(.CW(CNT_W)) u_words (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .words_i (words_i),
        .dec     (hold_end),
        .last_o  (last_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            strobe_o <= 1'b0;
            load_o   <= 1'b0;
            done_o   <= 1'b0;
            odd_word <= 1'b0;
        end else begin
            load_o <= 1'b0;
            done_o <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        odd_word <= 1'b0;
                        if (words_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            load_o <= 1'b1;
                            phase  <= PH_SETUP;
                        end
                    end
                end
                PH_SETUP: begin
                    if (setup_end) begin
                        strobe_o <= cfg.dt ? ~strobe_o : 1'b1;
                        phase    <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (!cfg.dt && tcount == TW'(unit) - TW'(1)) begin
                        strobe_o <= 1'b0;
                    end
                    if (hold_end) begin
                        if (last_word) begin
                            phase    <= PH_IDLE;
                            done_o   <= 1'b1;
                            strobe_o <= 1'b0;
                        end else begin
                            phase    <= PH_SETUP;
                            load_o   <= 1'b1;
                            odd_word <= ~odd_word;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stx_strobe_gen_chk.sv
module stx_strobe_gen_chk (
    input logic clk,
    input logic rst,
    input logic strobe_o,
    input logic load_o,
    input logic done_o
);

    assert_load_no_edge_R9: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $stable(strobe_o))
        else $error("strobe changed during load pulse");

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !strobe_o)
        else $error("strobe high while done");

    assert_after_done_low_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(done_o) && !load_o) |-> !strobe_o)
        else $error("strobe not parked after done");

    assert_done_no_load_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !load_o)
        else $error("load and done together");

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!strobe_o && !load_o && !done_o))
        else $error("outputs active after reset cycle");

endmodule

bind stx_strobe_gen stx_strobe_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_o (strobe_o),
    .load_o   (load_o),
    .done_o   (done_o)
);

// File: tb/tb_stx_strobe_gen.sv
module tb_stx_strobe_gen;

    localparam int DIV_W = 4;
    localparam int CNT_W = 8;
    localparam int MAXC  = 1024;

    typedef struct packed {
        logic [3:0] div;
        logic       dt;
        logic [3:0] ext;
        logic [7:0] words;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 4'b0000, 8'd3},  // R2 plain single-edge
        '{4'd3, 1'b0, 4'b0001, 8'd2},  // R2 rising setup
        '{4'd2, 1'b0, 4'b0100, 8'd2},  // R2 rising hold
        '{4'd2, 1'b0, 4'b1010, 8'd2},  // R4 falling bits in single-edge
        '{4'd1, 1'b1, 4'b0000, 8'd4},  // R3 double-edge plain
        '{4'd2, 1'b1, 4'b0101, 8'd3},  // R3 rising-edge extensions
        '{4'd2, 1'b1, 4'b1010, 8'd3},  // R3 falling-edge extensions
        '{4'd0, 1'b0, 4'b0000, 8'd2},  // R5 zero divisor single-edge
        '{4'd0, 1'b1, 4'b1111, 8'd3},  // R5 zero divisor double-edge
        '{4'd4, 1'b1, 4'b1111, 8'd1}   // R6 odd length parks strobe low
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_i = '0;
    logic             dt_mode_i = 1'b0;
    logic [3:0]       ext_i = '0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] words_i = '0;
    logic             strobe_o;
    logic             load_o;
    logic             done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    bit exp_s [MAXC];
    bit exp_l [MAXC];
    bit exp_d [MAXC];
    int total;

    always #5 clk = ~clk;

    stx_strobe_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .div_i(div_i), .dt_mode_i(dt_mode_i),
        .ext_i(ext_i), .start_i(start_i), .words_i(words_i),
        .strobe_o(strobe_o), .load_o(load_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected timeline from R2/R3/R5/R6/R8
    task automatic build_exp(input int d, input bit m, input bit [3:0] e,
                             input int w);
        int u, off, s, h;
        bit lvl;
        u = (d == 0) ? 1 : d;
        for (int i = 0; i < MAXC; i++) begin
            exp_s[i] = 0; exp_l[i] = 0; exp_d[i] = 0;
        end
        off = 0;
        lvl = 0;
        for (int k = 0; k < w; k++) begin
            exp_l[off] = 1;
            if (!m) begin
                s = 2 * u + e[0];
                h = 2 * u + e[2];
                for (int t = 0; t < u; t++) exp_s[off + s + t] = 1;
            end else begin
                s = u + ((k % 2 == 0) ? e[0] : e[1]);
                h = u + ((k % 2 == 0) ? e[2] : e[3]);
                for (int t = 0; t < s; t++) exp_s[off + t] = lvl;
                lvl = ~lvl;
                for (int t = 0; t < h; t++) exp_s[off + s + t] = lvl;
            end
            off += s + h;
        end
        exp_d[off] = 1;
        exp_s[off] = 0;
        total = off;
    endtask

    task automatic run_burst(input vec_t v, input bit chg, input string req);
        int bad_s, bad_l, bad_d;
        int as_, es_, al, el, ad, ed;
        build_exp(int'(v.div), v.dt, v.ext, int'(v.words));
        bad_s = 0; bad_l = 0; bad_d = 0;
        as_ = 0; es_ = 0; al = 0; el = 0; ad = 0; ed = 0;
        @(negedge clk);
        div_i = v.div; dt_mode_i = v.dt; ext_i = v.ext; words_i = v.words;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c <= total + 1; c++) begin
            if (bad_s == 0 && strobe_o !== exp_s[c]) begin
                bad_s = 1; as_ = strobe_o; es_ = exp_s[c];
                $display("  strobe mismatch at cycle %0d", c);
            end
            if (bad_l == 0 && load_o !== exp_l[c]) begin
                bad_l = 1; al = load_o; el = exp_l[c];
                $display("  load mismatch at cycle %0d", c);
            end
            if (bad_d == 0 && done_o !== exp_d[c]) begin
                bad_d = 1; ad = done_o; ed = exp_d[c];
                $display("  done mismatch at cycle %0d", c);
            end
            if (chg && c == 1) begin
                div_i = 4'd9; dt_mode_i = ~v.dt; ext_i = ~v.ext;
                words_i = 8'd7; start_i = 1'b1;
            end
            if (chg && c == 2) start_i = 1'b0;
            @(negedge clk);
        end
        check(bad_s == 0, req, "strobe timeline", as_, es_);
        check(bad_l == 0, req, "load timeline", al, el);
        check(bad_d == 0, req, "done timeline", ad, ed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs low, start ignored
        start_i = 1'b1; words_i = 8'd2; div_i = 4'd1;
        repeat (4) @(negedge clk);
        check(!strobe_o && !load_o && !done_o, "R1", "outputs in reset",
              {strobe_o, load_o, done_o}, 0);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!strobe_o && !load_o && !done_o, "R1", "outputs after reset",
              {strobe_o, load_o, done_o}, 0);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            run_burst(VECS[i], 1'b0, $sformatf("R2/R3/R4/R5/R6 vec%0d", i));
        end

        // R7: config changes and restart during a burst are ignored
        run_burst('{4'd2, 1'b0, 4'b0101, 8'd3}, 1'b1, "R7 single-edge");
        run_burst('{4'd1, 1'b1, 4'b0110, 8'd4}, 1'b1, "R7 double-edge");

        // R8: zero-word burst
        run_burst('{4'd3, 1'b1, 4'b1111, 8'd0}, 1'b0, "R8 zero words");

        // R6: strobe stays low while idle afterwards
        repeat (3) @(negedge clk);
        check(!strobe_o && !load_o && !done_o, "R6", "idle after burst",
              {strobe_o, load_o, done_o}, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule